// File: doc/BRIEF.md
# Audio Clock Ratio and Speed Detector

This block watches a master audio clock and a frame (left/right) clock. From them it works out the integer number of master-clock cycles per frame and the sample-rate class of the stream: single, double or quad speed. The whole block runs on one fixed reference clock. Both audio clocks are sampled through synchronizers and handled as edge events.

The frame period is measured as a count of master-clock rising edges between two frame-clock rising edges. That count is matched against the ten legal ratios. The same ratio can belong to two speed classes, so the block also counts master-clock edges over a fixed window of reference cycles. That window count gives the absolute master-clock rate, which settles the speed class for the shared ratios.

A result is reported only while both clocks are present. It is reported only after two consecutive frame measurements agree. Downstream divider logic uses the ratio code and the speed code once the locked flag is high.

Top module: `clk_ratio_detect`

## Requirements
- R1: While reset is asserted, ratio_code_o, speed_mode_o, locked_o and clocks_present_o are all zero.
- R2: The frame period is the number of master-clock rising edges from one frame-clock rising edge to the next. The legal ratios are coded in ascending order: 64=0, 96=1, 128=2, 192=3, 256=4, 384=5, 512=6, 768=7, 1024=8, 1152=9. No code above 9 ever appears.
- R3: A period within MATCH_TOL (default 2) of a legal ratio counts as that ratio. A period farther than that from every legal ratio leaves locked_o low.
- R4: locked_o rises only on the second of two consecutive measurements that give the same code, which is two frame periods after the clocks are first seen. A measurement that differs from the previous one clears locked_o at once. The new code is taken on the next agreeing measurement, and ratio_code_o never changes while locked_o stays high.
- R5: Speed codes are 0 single, 1 double and 2 quad, and code 3 never appears. Ratios 64 and 96 always report quad. Ratios 512 to 1152 always report single.
- R6: Ratios 128 and 192 report quad when the master-clock window count exceeds ratio*FS_QUAD_MIN*WIN_CYCLES/REF_HZ, and double otherwise. Ratios 256 and 384 report double when the count exceeds ratio*FS_DOUBLE_MIN*WIN_CYCLES/REF_HZ, and single otherwise.
- R7: If LRCK_TIMEOUT (default 2048) master-clock edges pass with no frame-clock rising edge, clocks_present_o and locked_o fall. Before that limit, both are unaffected.
- R8: A reference window of WIN_CYCLES cycles with no master-clock rising edge drops clocks_present_o and locked_o.
- R9: Detection runs only while both clocks are present. When the clocks return, a fresh pair of agreeing measurements is needed before locked_o rises again.
- R10: locked_o is never high while clocks_present_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fixed reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mclk_i | input | 1 | Master audio clock, sampled |
| lrck_i | input | 1 | Frame (left/right) clock, sampled |
| ratio_code_o | output | 4 | Detected ratio code (R2 encoding) |
| speed_mode_o | output | 2 | Speed class: 0 single, 1 double, 2 quad |
| locked_o | output | 1 | Ratio and speed are valid |
| clocks_present_o | output | 1 | Both audio clocks are currently seen |

## Verification
After a frame-clock edge has armed the meter, clocks_present_o follows one reference cycle later. A lock is then due two frame periods after that, and the bench brackets that interval between 1.5 and 2.5 periods. The speed code is already valid when lock is reached, because the master clock is only declared present at the end of a complete rate window. Loss of the frame clock is due after 2048 master edges, so the bench samples once well inside that bound and once safely past it. Loss of the master clock is due within two windows. Every other wait is a bounded poll on a port, and the result is sampled on the falling reference edge.

// File: rtl/ckdet_pkg.sv
`timescale 1ns / 1ps
package ckdet_pkg;

    localparam int unsigned NUM_RATIOS = 10;
    localparam int unsigned IDX_W      = $clog2(NUM_RATIOS);

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2
    } speed_e;

    // Legal master-to-frame ratios, ascending; index is the ratio code.
    function automatic int unsigned ratio_of(int unsigned idx);
        case (idx)
            0:       return 64;
            1:       return 96;
            2:       return 128;
            3:       return 192;
            4:       return 256;
            5:       return 384;
            6:       return 512;
            7:       return 768;
            8:       return 1024;
            9:       return 1152;
            default: return 0;
        endcase
    endfunction

    // Window count a master clock reaches at sample rate fs_hz with the given ratio.
    function automatic int unsigned rate_threshold(int unsigned ratio, int unsigned fs_hz,
                                                   int unsigned win, int unsigned ref_hz);
        longint unsigned prod;
        prod = 64'(ratio) * 64'(fs_hz) * 64'(win);
        return 32'(prod / 64'(ref_hz));
    endfunction

endpackage

// File: rtl/ckdet_edge_sync.sv
`timescale 1ns / 1ps
module ckdet_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES:0] pipe;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[STAGES-1:0], sig_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rise_o = s_q.pipe[STAGES-1] & ~s_q.pipe[STAGES];

endmodule

// File: rtl/ckdet_period_meter.sv
`timescale 1ns / 1ps
module ckdet_period_meter #(
    parameter int unsigned TIMEOUT = 2048,
    localparam int unsigned CNT_W  = $clog2(TIMEOUT + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             mclk_rise_i,
    input  logic             lrck_rise_i,
    output logic             meas_valid_o,
    output logic [CNT_W-1:0] meas_o,
    output logic             armed_o
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(TIMEOUT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] meas;
        logic             vld;
        logic             armed;
    } per_t;

    per_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (!en_i) begin
            s_d.cnt   = '0;
            s_d.armed = 1'b0;
        end else if (lrck_rise_i) begin
            // close one frame period, open the next
            s_d.vld   = s_q.armed && (s_q.cnt != TOP);
            s_d.meas  = s_q.cnt;
            s_d.armed = 1'b1;
            s_d.cnt   = mclk_rise_i ? CNT_W'(1) : '0;
        end else begin
            if (mclk_rise_i && (s_q.cnt != TOP)) s_d.cnt = s_q.cnt + CNT_W'(1);
            if (s_q.cnt == TOP)                  s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign meas_valid_o = s_q.vld;
    assign meas_o       = s_q.meas;
    assign armed_o      = s_q.armed;

endmodule

// File: rtl/ckdet_rate_meter.sv
`timescale 1ns / 1ps
module ckdet_rate_meter #(
    parameter int unsigned WIN     = 4096,
    localparam int unsigned RATE_W = $clog2(WIN + 1),
    localparam int unsigned TICK_W = $clog2(WIN)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mclk_rise_i,
    output logic [RATE_W-1:0] rate_o,
    output logic              mclk_ok_o
);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [RATE_W-1:0] acc;
        logic [RATE_W-1:0] rate;
        logic              ok;
    } rate_t;

    rate_t s_d, s_q;
    logic [RATE_W-1:0] sum;

    always_comb begin
        s_d = s_q;
        sum = s_q.acc + (mclk_rise_i ? RATE_W'(1) : RATE_W'(0));
        if (s_q.tick == TICK_W'(WIN - 1)) begin
            s_d.tick = '0;
            s_d.acc  = '0;
            s_d.rate = sum;
            s_d.ok   = (sum != '0);
        end else begin
            s_d.tick = s_q.tick + TICK_W'(1);
            s_d.acc  = sum;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rate_o    = s_q.rate;
    assign mclk_ok_o = s_q.ok;

endmodule

// File: rtl/clk_ratio_detect.sv
`timescale 1ns / 1ps
module clk_ratio_detect
    import ckdet_pkg::*;
#(
    parameter int unsigned REF_HZ        = 200_000_000,
    parameter int unsigned WIN_CYCLES    = 4096,
    parameter int unsigned LRCK_TIMEOUT  = 2048,
    parameter int unsigned MATCH_TOL     = 2,
    parameter int unsigned FS_QUAD_MIN   = 112_000,
    parameter int unsigned FS_DOUBLE_MIN = 56_000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mclk_i,
    input  logic             lrck_i,
    output logic [IDX_W-1:0] ratio_code_o,
    output logic [1:0]       speed_mode_o,
    output logic             locked_o,
    output logic             clocks_present_o
);

    localparam int unsigned PER_W  = $clog2(LRCK_TIMEOUT + 1);
    localparam int unsigned RATE_W = $clog2(WIN_CYCLES + 1);

    localparam logic [RATE_W-1:0] TH_Q2 = RATE_W'(rate_threshold(ratio_of(2), FS_QUAD_MIN, WIN_CYCLES, REF_HZ));
    localparam logic [RATE_W-1:0] TH_Q3 = RATE_W'(rate_threshold(ratio_of(3), FS_QUAD_MIN, WIN_CYCLES, REF_HZ));
    localparam logic [RATE_W-1:0] TH_D4 = RATE_W'(rate_threshold(ratio_of(4), FS_DOUBLE_MIN, WIN_CYCLES, REF_HZ));
    localparam logic [RATE_W-1:0] TH_D5 = RATE_W'(rate_threshold(ratio_of(5), FS_DOUBLE_MIN, WIN_CYCLES, REF_HZ));

    // bit 0: master clock, bit 1: frame clock
    logic [1:0] raw, rise;
    assign raw = {lrck_i, mclk_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        ckdet_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .sig_i  (raw[g]),
            .rise_o (rise[g])
        );
    end

    logic              mclk_ok;
    logic [RATE_W-1:0] rate;

    ckdet_rate_meter #(.WIN(WIN_CYCLES)) u_rate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mclk_rise_i (rise[0]),
        .rate_o      (rate),
        .mclk_ok_o   (mclk_ok)
    );

    logic             meas_vld, armed;
    logic [PER_W-1:0] meas;

    ckdet_period_meter #(.TIMEOUT(LRCK_TIMEOUT)) u_period (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .en_i         (mclk_ok),
        .mclk_rise_i  (rise[0]),
        .lrck_rise_i  (rise[1]),
        .meas_valid_o (meas_vld),
        .meas_o       (meas),
        .armed_o      (armed)
    );

    // match the period against the legal ratios
    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int unsigned i = 0; i < NUM_RATIOS; i++) begin
            if (!hit && (meas >= PER_W'(ratio_of(i) - MATCH_TOL))
                     && (meas <= PER_W'(ratio_of(i) + MATCH_TOL))) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    function automatic speed_e classify(logic [IDX_W-1:0] idx, logic [RATE_W-1:0] r);
        case (idx)
            IDX_W'(0), IDX_W'(1): return SPD_QUAD;
            IDX_W'(2):            return (r > TH_Q2) ? SPD_QUAD : SPD_DOUBLE;
            IDX_W'(3):            return (r > TH_Q3) ? SPD_QUAD : SPD_DOUBLE;
            IDX_W'(4):            return (r > TH_D4) ? SPD_DOUBLE : SPD_SINGLE;
            IDX_W'(5):            return (r > TH_D5) ? SPD_DOUBLE : SPD_SINGLE;
            default:              return SPD_SINGLE;
        endcase
    endfunction

    typedef struct packed {
        logic [IDX_W-1:0] ratio;
        logic [IDX_W-1:0] prev_idx;
        speed_e           mode;
        logic             prev_hit;
        logic             locked;
        logic             present;
    } det_t;

    det_t s_d, s_q;
    logic pres;

    always_comb begin
        s_d         = s_q;
        pres        = mclk_ok & armed;
        s_d.present = pres;
        if (!pres) begin
            s_d.locked   = 1'b0;
            s_d.prev_hit = 1'b0;
        end else if (meas_vld) begin
            if (!hit) begin
                s_d.locked = 1'b0;
            end else if (s_q.prev_hit && (s_q.prev_idx == hit_idx)) begin
                s_d.locked = 1'b1;
                s_d.ratio  = hit_idx;
            end else begin
                s_d.locked = 1'b0;
            end
            s_d.prev_hit = hit;
            s_d.prev_idx = hit_idx;
        end
        s_d.mode = classify(s_d.ratio, rate);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign ratio_code_o     = s_q.ratio;
    assign speed_mode_o     = s_q.mode;
    assign locked_o         = s_q.locked;
    assign clocks_present_o = s_q.present;

endmodule

// File: rtl/ckdet_checker.sv
`timescale 1ns / 1ps
module ckdet_checker
    import ckdet_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic [IDX_W-1:0] ratio_code_o,
    input logic [1:0]       speed_mode_o,
    input logic             locked_o,
    input logic             clocks_present_o
);

    a_r10_lock_needs_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |-> clocks_present_o);

    a_r2_code_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ratio_code_o < IDX_W'(NUM_RATIOS));

    a_r5_no_mode_three: assert property (@(posedge clk_i) disable iff (!rst_ni)
        speed_mode_o != 2'd3);

    a_r5_low_ratio_quad: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && ratio_code_o <= IDX_W'(1)) |-> speed_mode_o == SPD_QUAD);

    a_r5_high_ratio_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && ratio_code_o >= IDX_W'(6)) |-> speed_mode_o == SPD_SINGLE);

    a_r6_shared_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && (ratio_code_o == IDX_W'(2) || ratio_code_o == IDX_W'(3)))
            |-> speed_mode_o != SPD_SINGLE);

    a_r6_shared_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && (ratio_code_o == IDX_W'(4) || ratio_code_o == IDX_W'(5)))
            |-> speed_mode_o != SPD_QUAD);

    a_r4_code_stable_in_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && $past(locked_o)) |-> $stable(ratio_code_o));

endmodule

bind clk_ratio_detect ckdet_checker u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .ratio_code_o     (ratio_code_o),
    .speed_mode_o     (speed_mode_o),
    .locked_o         (locked_o),
    .clocks_present_o (clocks_present_o)
);

// File: tb/clk_ratio_detect_tb_top.sv
`timescale 1ns / 1ps
module clk_ratio_detect_tb_top;
    import ckdet_pkg::*;

    localparam int WIN   = 1024;
    localparam int N_VEC = 14;
    localparam int V_RATIO [N_VEC] = '{64, 96, 128, 128, 192, 192, 256, 256, 384, 384, 512, 768, 1024, 1152};
    localparam int V_HALF  [N_VEC] = '{2, 2, 4, 8, 2, 8, 4, 8, 4, 8, 2, 2, 2, 2};
    localparam int V_CODE  [N_VEC] = '{0, 1, 2, 2, 3, 3, 4, 4, 5, 5, 6, 7, 8, 9};
    localparam int V_MODE  [N_VEC] = '{2, 2, 2, 1, 2, 1, 1, 0, 1, 0, 0, 0, 0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk = 1'b0;
    logic lrck = 1'b0;
    logic [IDX_W-1:0] ratio_code;
    logic [1:0] speed_mode;
    logic locked, present;

    int half_g = 2, ratio_g = 64;
    bit run_mclk = 1'b1, run_lrck = 1'b1;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clk_ratio_detect #(.WIN_CYCLES(WIN)) dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .mclk_i           (mclk),
        .lrck_i           (lrck),
        .ratio_code_o     (ratio_code),
        .speed_mode_o     (speed_mode),
        .locked_o         (locked),
        .clocks_present_o (present)
    );

    // audio clock generator: frame period = ratio_g master cycles
    initial begin
        int tick_c, fall_c;
        tick_c = 0;
        fall_c = 0;
        forever begin
            @(negedge clk);
            if (run_mclk) begin
                tick_c++;
                if (tick_c >= half_g) begin
                    tick_c = 0;
                    mclk = ~mclk;
                    if (!mclk) begin
                        fall_c++;
                        if (fall_c >= ratio_g / 2) begin
                            fall_c = 0;
                            if (run_lrck) lrck = ~lrck;
                        end
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic poll_locked(input bit level, input int limit, output int waited);
        waited = 0;
        while (locked !== level && waited < limit) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cycles(6);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        finish_run();
    end

    initial begin
        int w;
        // R1: reset state
        wait_cycles(8);
        check(ratio_code == '0, "R1 ratio", int'(ratio_code), 0);
        check(speed_mode == 2'd0, "R1 mode", int'(speed_mode), 0);
        check(locked == 1'b0, "R1 locked", int'(locked), 0);
        check(present == 1'b0, "R1 present", int'(present), 0);

        // table walk: R2 codes, R5 fixed modes, R6 shared-ratio modes
        for (int v = 0; v < N_VEC; v++) begin
            half_g  = V_HALF[v];
            ratio_g = V_RATIO[v];
            do_reset();
            poll_locked(1'b1, 4 * V_RATIO[v] * 2 * V_HALF[v] + 2 * WIN + 100, w);
            wait_cycles(4);
            check(locked == 1'b1, "R2 lock", int'(locked), 1);
            check(int'(ratio_code) == V_CODE[v], "R2 code", int'(ratio_code), V_CODE[v]);
            check(int'(speed_mode) == V_MODE[v],
                  (V_CODE[v] >= 2 && V_CODE[v] <= 5) ? "R6 mode" : "R5 mode",
                  int'(speed_mode), V_MODE[v]);
        end

        // R4: lock two frame periods after clocks are seen
        half_g  = 2;
        ratio_g = 64;
        do_reset();
        w = 0;
        while (present !== 1'b1 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        check(present == 1'b1, "R4 present", int'(present), 1);
        poll_locked(1'b1, 2000, w);
        check(w >= 384 && w <= 640, "R4 lock delay", w, 512);

        // R4: ratio change drops lock, then relocks on new ratio
        ratio_g = 96;
        poll_locked(1'b0, 1300, w);
        check(locked == 1'b0, "R4 drop on change", int'(locked), 0);
        poll_locked(1'b1, 2000, w);
        wait_cycles(2);
        check(locked == 1'b1 && ratio_code == IDX_W'(1), "R4 relock code", int'(ratio_code), 1);

        // R3: within tolerance matches, outside does not
        ratio_g = 66;
        poll_locked(1'b0, 1500, w);
        poll_locked(1'b1, 1500, w);
        wait_cycles(2);
        check(locked == 1'b1 && ratio_code == IDX_W'(0), "R3 near 64", int'(ratio_code), 0);
        ratio_g = 70;
        poll_locked(1'b0, 1500, w);
        wait_cycles(6 * 70 * 4);
        check(locked == 1'b0, "R3 off-grid unlocked", int'(locked), 0);
        check(present == 1'b1, "R3 clocks still present", int'(present), 1);

        // R7: frame clock loss after 2048 master edges
        ratio_g = 64;
        poll_locked(1'b1, 2000, w);
        wait_cycles(2);
        run_lrck = 1'b0;
        wait_cycles(6000);
        check(present == 1'b1 && locked == 1'b1, "R7 before timeout", int'(locked), 1);
        wait_cycles(2800);
        check(present == 1'b0, "R7 present after timeout", int'(present), 0);
        check(locked == 1'b0, "R7 locked after timeout", int'(locked), 0);

        // R9: fresh detection when frame clock returns
        run_lrck = 1'b1;
        poll_locked(1'b1, 3000, w);
        wait_cycles(2);
        check(locked == 1'b1 && ratio_code == IDX_W'(0), "R9 relock after frame", int'(ratio_code), 0);

        // R8: master clock loss
        run_mclk = 1'b0;
        wait_cycles(2 * WIN + 20);
        check(present == 1'b0, "R8 present", int'(present), 0);
        check(locked == 1'b0, "R8 locked", int'(locked), 0);

        // R9: master clock returns, lock again
        run_mclk = 1'b1;
        poll_locked(1'b1, 2 * WIN + 2000, w);
        wait_cycles(2);
        check(locked == 1'b1 && ratio_code == IDX_W'(0), "R9 relock after master", int'(ratio_code), 0);
        check(speed_mode == 2'd2, "R5 quad after relock", int'(speed_mode), 2);

        finish_run();
    end

endmodule